// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

A small word-addressed store in which every word carries a one-bit presence tag saying whether the word holds a value that has not yet been consumed. Several requesters share it through a fixed number of request ports. Besides ordinary reads and writes, the block offers tag-aware operations. These let hardware threads hand values from producer to consumer in order and build locks without any software polling loop.

An operation that needs a full word stalls while that word's tag is empty. The requester sees its ready bit held low and keeps its request asserted; the request is re-evaluated every cycle. Among the requests that can proceed, a round-robin arbiter grants one per cycle. A granted request updates the store at the clock edge that ends the grant cycle. Read data comes back one cycle later on a shared data bus, qualified by a per-port response bit.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is full and every data word is zero; no ready or response bit is set while no request is valid.
- R2: Operation code 0 (plain read) and code 2 (read-when-full) return the addressed word on `rsp_rdata_o` in the cycle after the grant, with only the granting port's bit of `rsp_valid_o` set; read-when-full leaves the tag full.
- R3: Code 2 (read-when-full) and code 3 (take) are not granted while the addressed tag is empty; the request is retried every cycle and is granted once the tag becomes full.
- R4: Code 3 (take, the lock operation) returns the word and sets its tag to empty, so later read-when-full and take requests to that word stall.
- R5: Code 4 (fill, the producer write and the unlock) writes the word and sets its tag to full, whatever the prior tag; it never stalls and gives no response.
- R6: Code 5 (drain, the start of a produce) sets the tag to empty and leaves the data unchanged; it gives no response.
- R7: Code 1 (plain write) and code 0 (plain read) never stall, ignore the tag and leave it unchanged.
- R8: At most one request is granted per cycle, only to a valid request that may proceed, and one is always granted when any can. The search starts at port 0 after reset and, after a grant to port g, starts at port g+1 (wrapping).
- R9: When a take and a read-when-full reach the same full word in one cycle, only the granted one sees it full; the other sees the updated tag from the next cycle.
- R10: Codes 6 and 7 are granted without stalling, change no data or tag and give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_REQ | Request present, one bit per port |
| req_op_i | input | NUM_REQ*3 | Operation code per port, port p in bits [3p+2:3p] |
| req_addr_i | input | NUM_REQ*ADDR_W | Word address per port |
| req_wdata_i | input | NUM_REQ*DATA_W | Write data per port |
| req_ready_o | output | NUM_REQ | Grant: request completes at this clock edge |
| rsp_valid_o | output | NUM_REQ | Read data valid for this port |
| rsp_rdata_o | output | DATA_W | Read data, shared by all ports |

## Verification
A single requester walks a vector table that moves one word through every tag transition: plain accesses on both tag states, drain then stalled waiting reads, fill releasing them, take locking and fill unlocking, fill on an already full word, and the unused codes. This separates tag-ignoring operations from tag-honouring ones and shows whether data survives drains and unused codes. Directed multi-port patterns then hold three and then two requests at once to tell a rotating grant from a fixed-priority one. A same-cycle take against read-when-full on one word shows that the loser sees the new empty tag rather than a stale full one.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_READ_FULL = 3'd2,
    OP_TAKE      = 3'd3,
    OP_FILL      = 3'd4,
    OP_DRAIN     = 3'd5
  } fe_op_e;

  function automatic logic op_blocks(logic [OP_W-1:0] op);
    return (op == OP_READ_FULL) || (op == OP_TAKE);
  endfunction

  function automatic logic op_reads(logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_READ_FULL) || (op == OP_TAKE);
  endfunction

  function automatic logic op_writes(logic [OP_W-1:0] op);
    return (op == OP_WRITE) || (op == OP_FILL);
  endfunction

  function automatic logic op_tags(logic [OP_W-1:0] op);
    return (op == OP_TAKE) || (op == OP_FILL) || (op == OP_DRAIN);
  endfunction
endpackage

// File: rtl/fe_sync_store.sv
module fe_sync_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              tag_en_i,
  input  logic              tag_val_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DEPTH-1:0]  tags_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  tags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) data_q[d] <= '0;
      tags_q <= '1;
    end else begin
      if (wr_en_i)  data_q[addr_i] <= wdata_i;
      if (tag_en_i) tags_q[addr_i] <= tag_val_i;
    end
  end

  assign rdata_o = data_q[addr_i];
  assign tags_o  = tags_q;

  // tags move only on a tag-changing grant
  p_tag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_en_i |=> tags_o == $past(tags_o));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> data_q[$past(addr_i)] == $past(rdata_o));
endmodule

// File: rtl/fe_sync_rr_arb.sv
module fe_sync_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int            cand;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    cand  = 0;
    for (int k = 0; k < N; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (!found && req_i[cand]) begin
        found       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (|gnt_o)     ptr_q <= (int'(idx_o) == N-1) ? '0 : idx_o + 1'b1;
  end

  p_gnt_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_work_conserving_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_sync_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [NUM_REQ*OP_W-1:0]     req_op_i,
  input  logic [NUM_REQ*ADDR_W-1:0]   req_addr_i,
  input  logic [NUM_REQ*DATA_W-1:0]   req_wdata_i,
  output logic [NUM_REQ-1:0]          req_ready_o,
  output logic [NUM_REQ-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]           rsp_rdata_o
);
  logic [OP_W-1:0]   op_a    [NUM_REQ];
  logic [ADDR_W-1:0] addr_a  [NUM_REQ];
  logic [DATA_W-1:0] wdata_a [NUM_REQ];
  logic [NUM_REQ-1:0] elig, gnt;
  logic [IDX_W-1:0]  gnt_idx;
  logic [DEPTH-1:0]  tags_w;
  logic [DATA_W-1:0] rdata_w;
  logic [OP_W-1:0]   sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              any_gnt;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_port
    assign op_a[g]    = req_op_i[g*OP_W +: OP_W];
    assign addr_a[g]  = req_addr_i[g*ADDR_W +: ADDR_W];
    assign wdata_a[g] = req_wdata_i[g*DATA_W +: DATA_W];
    // stall tag-honouring reads on an empty word
    assign elig[g] = req_valid_i[g] && (!op_blocks(op_a[g]) || tags_w[addr_a[g]]);

    p_block_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ready_o[g] && op_blocks(op_a[g])) |-> tags_w[addr_a[g]]);
  end

  fe_sync_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .gnt_o  (gnt),
    .idx_o  (gnt_idx)
  );

  assign any_gnt   = |gnt;
  assign sel_op    = op_a[gnt_idx];
  assign sel_addr  = addr_a[gnt_idx];
  assign sel_wdata = wdata_a[gnt_idx];

  fe_sync_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (any_gnt && op_writes(sel_op)),
    .tag_en_i  (any_gnt && op_tags(sel_op)),
    .tag_val_i (sel_op == OP_FILL),
    .addr_i    (sel_addr),
    .wdata_i   (sel_wdata),
    .rdata_o   (rdata_w),
    .tags_o    (tags_w)
  );

  logic [NUM_REQ-1:0] rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= op_reads(sel_op) ? gnt : '0;
      if (any_gnt && op_reads(sel_op)) rsp_data_q <= rdata_w;
    end
  end

  assign req_ready_o = gnt;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  // last grant, kept for the tag checks below
  logic              chk_take_q, chk_fill_q, chk_drain_q;
  logic [ADDR_W-1:0] chk_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_take_q  <= 1'b0;
      chk_fill_q  <= 1'b0;
      chk_drain_q <= 1'b0;
      chk_addr_q  <= '0;
    end else begin
      chk_take_q  <= any_gnt && (sel_op == OP_TAKE);
      chk_fill_q  <= any_gnt && (sel_op == OP_FILL);
      chk_drain_q <= any_gnt && (sel_op == OP_DRAIN);
      chk_addr_q  <= sel_addr;
    end
  end

  p_take_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take_q |-> !tags_w[chk_addr_q]);
  p_fill_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_fill_q |-> tags_w[chk_addr_q]);
  p_drain_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_drain_q |-> !tags_w[chk_addr_q]);
  p_rsp_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
  p_ready_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
endmodule

// File: tb/fe_sync_mem_tb_top.sv
module fe_sync_mem_tb_top;
  import fe_sync_pkg::*;

  localparam int NR = 3;
  localparam int DP = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk, rst_n;
  logic [NR-1:0]    vld;
  logic [2:0]       opv [NR];
  logic [AW-1:0]    adv [NR];
  logic [DW-1:0]    wdv [NR];
  logic [NR*3-1:0]  req_op;
  logic [NR*AW-1:0] req_addr;
  logic [NR*DW-1:0] req_wdata;
  logic [NR-1:0]    req_ready, rsp_valid;
  logic [DW-1:0]    rsp_rdata;

  always_comb begin
    for (int p = 0; p < NR; p++) begin
      req_op[p*3 +: 3]     = opv[p];
      req_addr[p*AW +: AW] = adv[p];
      req_wdata[p*DW +: DW] = wdv[p];
    end
  end

  fe_sync_mem #(.NUM_REQ(NR), .DEPTH(DP), .DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (vld),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_ready_o (req_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic en, input logic [2:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    vld[p] = en;
    opv[p] = op;
    adv[p] = a;
    wdv[p] = d;
  endtask

  // reference rotating pick over the set of proceeding requests
  function automatic int pick(input logic [NR-1:0] el, input int ptr);
    for (int k = 0; k < NR; k++) begin
      if (el[(ptr + k) % NR]) return (ptr + k) % NR;
    end
    return -1;
  endfunction

  typedef struct packed {
    logic [3:0]    rq;
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          rdy;
    logic [DW-1:0] rd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{4'd1,  3'd0, 3'd1, 16'h0000, 1'b1, 16'h0000}, // R1 reset data
    '{4'd7,  3'd1, 3'd1, 16'h1111, 1'b1, 16'h0000}, // R7 plain write
    '{4'd2,  3'd2, 3'd1, 16'h0000, 1'b1, 16'h1111}, // R2 read-when-full
    '{4'd6,  3'd5, 3'd1, 16'h0000, 1'b1, 16'h0000}, // R6 drain
    '{4'd6,  3'd0, 3'd1, 16'h0000, 1'b1, 16'h1111}, // R6 data kept
    '{4'd3,  3'd2, 3'd1, 16'h0000, 1'b0, 16'h0000}, // R3 stall
    '{4'd3,  3'd3, 3'd1, 16'h0000, 1'b0, 16'h0000}, // R3 take stalls
    '{4'd7,  3'd1, 3'd1, 16'h2222, 1'b1, 16'h0000}, // R7 write on empty
    '{4'd7,  3'd2, 3'd1, 16'h0000, 1'b0, 16'h0000}, // R7 tag still empty
    '{4'd5,  3'd4, 3'd1, 16'h3333, 1'b1, 16'h0000}, // R5 fill
    '{4'd3,  3'd2, 3'd1, 16'h0000, 1'b1, 16'h3333}, // R3 released
    '{4'd4,  3'd3, 3'd1, 16'h0000, 1'b1, 16'h3333}, // R4 take
    '{4'd4,  3'd2, 3'd1, 16'h0000, 1'b0, 16'h0000}, // R4 locked
    '{4'd5,  3'd4, 3'd1, 16'h4444, 1'b1, 16'h0000}, // R5 unlock
    '{4'd4,  3'd3, 3'd1, 16'h0000, 1'b1, 16'h4444}, // R4 take again
    '{4'd5,  3'd4, 3'd1, 16'h5555, 1'b1, 16'h0000}, // R5 fill on empty
    '{4'd5,  3'd4, 3'd1, 16'h6666, 1'b1, 16'h0000}, // R5 fill on full
    '{4'd2,  3'd0, 3'd1, 16'h0000, 1'b1, 16'h6666}, // R2 plain read
    '{4'd10, 3'd6, 3'd1, 16'h7777, 1'b1, 16'h0000}, // R10 code 6
    '{4'd10, 3'd0, 3'd1, 16'h0000, 1'b1, 16'h6666}, // R10 data kept
    '{4'd10, 3'd7, 3'd7, 16'h7777, 1'b1, 16'h0000}, // R10 code 7
    '{4'd1,  3'd2, 3'd7, 16'h0000, 1'b1, 16'h0000}  // R1 top word full, zero
  };

  initial begin
    logic exp_rsp;
    int   e, eptr;
    rst_n = 1'b0;
    for (int p = 0; p < NR; p++) drive(p, 1'b0, 3'd0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 ready after reset", {29'b0, req_ready}, 32'h0);
    chk("R1 rsp after reset", {29'b0, rsp_valid}, 32'h0);
    @(negedge clk);

    // vector walk on port 0
    for (int i = 0; i < NV; i++) begin
      drive(0, 1'b1, VT[i].op, VT[i].addr, VT[i].wd);
      #2;
      chk($sformatf("R%0d vec%0d ready", VT[i].rq, i), {31'b0, req_ready[0]}, {31'b0, VT[i].rdy});
      @(negedge clk);
      drive(0, 1'b0, 3'd0, '0, '0);
      exp_rsp = VT[i].rdy && (VT[i].op == 3'd0 || VT[i].op == 3'd2 || VT[i].op == 3'd3);
      chk($sformatf("R%0d vec%0d rsp_valid", VT[i].rq, i), {29'b0, rsp_valid}, {31'b0, exp_rsp});
      if (exp_rsp)
        chk($sformatf("R%0d vec%0d rdata", VT[i].rq, i), {16'b0, rsp_rdata}, {16'b0, VT[i].rd});
    end

    // R8: three held requests, last grant was port 0
    eptr = 1;
    for (int p = 0; p < NR; p++) drive(p, 1'b1, 3'd0, AW'(p + 1), '0);
    for (int c = 0; c < 3; c++) begin
      #2;
      e = pick(vld, eptr);
      chk("R8 rotation three ports", {29'b0, req_ready}, 32'(1) << e);
      eptr = (e + 1) % NR;
      @(negedge clk);
      vld[e] = 1'b0;
    end
    #2;
    chk("R8 idle after drain", {29'b0, req_ready}, 32'h0);
    @(negedge clk);

    // R8: two continuous requesters alternate
    drive(0, 1'b1, 3'd0, 3'd2, '0);
    drive(1, 1'b1, 3'd0, 3'd3, '0);
    for (int c = 0; c < 3; c++) begin
      #2;
      e = pick(vld, eptr);
      chk("R8 alternation", {29'b0, req_ready}, 32'(1) << e);
      eptr = (e + 1) % NR;
      @(negedge clk);
    end
    vld = '0;

    // R9: take (port 0) vs read-when-full (port 1) on full word 5; port 0 first
    drive(0, 1'b1, 3'd3, 3'd5, '0);
    drive(1, 1'b1, 3'd2, 3'd5, '0);
    #2;
    chk("R9 single winner", {29'b0, req_ready}, 32'h1);
    @(negedge clk);
    vld[0] = 1'b0;
    #2;
    chk("R9 loser sees empty", {29'b0, req_ready}, 32'h0);
    @(negedge clk);
    drive(2, 1'b1, 3'd4, 3'd5, 16'h0A0A);
    #2;
    chk("R9 fill proceeds", {29'b0, req_ready}, 32'h4);
    @(negedge clk);
    vld[2] = 1'b0;
    #2;
    chk("R3 waiter released", {29'b0, req_ready}, 32'h2);
    @(negedge clk);
    vld[1] = 1'b0;
    chk("R2 waiter rsp port", {29'b0, rsp_valid}, 32'h2);
    chk("R2 waiter data", {16'b0, rsp_rdata}, 32'h0A0A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule